// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers 32 interrupt request lines, each of which can also be forced high by software. It sorts every request into one of two classes, fast or normal. Requests in the fast class drive the `fiq_o` output to the processor. Requests in the normal class drive `irq_o`. Sixteen priority slots can each be pointed at any request source. When the processor reads the vector register, the block returns the handler address of the most urgent slot whose source is currently requesting. If no slot applies, it returns a programmable default handler address.

While a slot is being serviced, that slot and all less urgent slots are held off the vector output, and more urgent slots can still preempt it. The service routine writes the vector register to signal that it has finished. Each such write releases the most urgent level still being held, so nested service works naturally. Software reaches all of the state through a flat map of 32-bit word registers. Read data is returned one cycle after the read strobe.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, all control registers and the service hold are zero, and `fiq_o`, `irq_o` and `rdata_o` are low. This covers enable, class, soft-force, slot control and default address. The slot handler address table is not reset.
- R2: Reading offset 0x000 returns the 32 raw requests, `req_i` OR the soft-force bits, regardless of enable or class.
- R3: Writing offset 0x00C sets the enable bits that are 1 in the data. Writing offset 0x010 clears them. Zero data bits leave enables unchanged in both cases. Reading 0x00C returns the enables.
- R4: The class register at 0x014 is read/write, where bit value 1 means fast class. One cycle after its inputs, `fiq_o` is the OR of the requests that are enabled and in the fast class. Reading 0x008 returns that masked set.
- R5: One cycle after its inputs, `irq_o` is the OR of the requests that are enabled and in the normal class, whether or not they are vectored. Reading 0x004 returns that masked set.
- R6: Writing 1s to 0x018 sets soft-force bits, and writing 1s to 0x01C clears them. Zero bits have no effect. Reading 0x018 returns the soft-force bits.
- R7: Slot n has a control word at 0x100+4n and a handler address at 0x200+4n. In the control word, bits 4:0 are the source number and bit 5 is the slot enable. Reading the vector register at 0x020 returns the handler address of the lowest-numbered slot that meets all of these conditions: the slot is enabled, its source is requesting and enabled, its source is in the normal class, and it is not held.
- R8: When no slot qualifies, a vector read returns the default address register at 0x024. A request with no enabled slot still asserts `irq_o`.
- R9: When two enabled slots name the same source, the vector read returns the lower-numbered slot's address.
- R10: A vector read that returns slot k marks k as in service. After that, slots k and above are held off the vector output, while slots below k still win. A write to 0x020 releases the most urgent slot in service. Its data is ignored and does not change any stored value.
- R11: `rdata_o` carries the read result in the cycle after `rd_en_i` and is zero otherwise. An address with bits 1:0 not zero, or an unmapped offset, reads as zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 32 | Interrupt request lines, active high |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 12 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid one cycle after `rd_en_i` |
| fiq_o | output | 1 | Fast interrupt to the processor |
| irq_o | output | 1 | Normal interrupt to the processor |

## Verification
The bench targets the following corner cases, each named with the fault that would show it:
- Two enabled slots sharing one source: a design that scans from the wrong end returns the later slot's address.
- A second vector read while a slot is held: it must give the default address, and a design without the hold repeats the held handler.
- A more urgent source that arrives during service: it must preempt, and a design that masks everything blocks it.
- Release by a vector write: a design that pops the wrong level returns the wrong address afterwards.
- A slot source moved into the fast class: it must drop out of vectoring and show only on `fiq_o`.
- Misaligned accesses: they must read zero and write nothing, which catches decoders that ignore the low address bits.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int REG_AW = 12;
  localparam logic [REG_AW-1:0] OFF_RAW    = 12'h000;
  localparam logic [REG_AW-1:0] OFF_IRQST  = 12'h004;
  localparam logic [REG_AW-1:0] OFF_FIQST  = 12'h008;
  localparam logic [REG_AW-1:0] OFF_ENSET  = 12'h00C;
  localparam logic [REG_AW-1:0] OFF_ENCLR  = 12'h010;
  localparam logic [REG_AW-1:0] OFF_CLASS  = 12'h014;
  localparam logic [REG_AW-1:0] OFF_SSET   = 12'h018;
  localparam logic [REG_AW-1:0] OFF_SCLR   = 12'h01C;
  localparam logic [REG_AW-1:0] OFF_VECT   = 12'h020;
  localparam logic [REG_AW-1:0] OFF_DEFVEC = 12'h024;
  localparam logic [3:0] PAGE_CTL  = 4'h1;
  localparam logic [3:0] PAGE_HADR = 4'h2;
endpackage

// File: rtl/vic_slot_arbiter.sv
module vic_slot_arbiter #(
  parameter int NUM_SLOT = 16,
  localparam int SLOT_W = $clog2(NUM_SLOT)
) (
  input  logic [NUM_SLOT-1:0] hit_i,
  input  logic [NUM_SLOT-1:0] allow_i,
  output logic                found_o,
  output logic [SLOT_W-1:0]   idx_o
);
  // lowest-numbered allowed hit wins; scanning downward lets it overwrite
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = NUM_SLOT - 1; i >= 0; i--) begin
      if (hit_i[i] && allow_i[i]) begin
        found_o = 1'b1;
        idx_o   = SLOT_W'(i);
      end
    end
  end
endmodule

// File: rtl/vic_service_track.sv
module vic_service_track #(
  parameter int NUM_SLOT = 16,
  localparam int SLOT_W = $clog2(NUM_SLOT)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                push_i,
  input  logic [SLOT_W-1:0]   push_idx_i,
  input  logic                pop_i,
  output logic [NUM_SLOT-1:0] allow_o,
  output logic [NUM_SLOT-1:0] svc_o
);
  logic [NUM_SLOT-1:0] svc_nxt;
  logic [NUM_SLOT-1:0] lowbit;

  always_comb begin
    svc_nxt = svc_o;
    if (pop_i)  svc_nxt = svc_nxt & (svc_nxt - 1'b1);
    if (push_i) svc_nxt[push_idx_i] = 1'b1;
  end

  // only slots more urgent than the most urgent in-service slot may win
  assign lowbit  = svc_o & (~svc_o + 1'b1);
  assign allow_o = (svc_o == '0) ? '1 : (lowbit - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) svc_o <= '0;
    else     svc_o <= svc_nxt;
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import vic_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_SLOT = 16,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_SRC-1:0]  req_i,
  input  logic                wr_en_i,
  input  logic                rd_en_i,
  input  logic [REG_AW-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                fiq_o,
  output logic                irq_o
);
  localparam int SRC_W  = $clog2(NUM_SRC);
  localparam int SLOT_W = $clog2(NUM_SLOT);
  localparam int CTL_W  = SRC_W + 1;

  logic [NUM_SRC-1:0]  en_q, cls_q, soft_q;
  logic [NUM_SRC-1:0]  raw_w, act_w;
  logic [CTL_W-1:0]    ctl_q [NUM_SLOT];
  logic [DATA_W-1:0]   hadr_mem [NUM_SLOT];
  logic [DATA_W-1:0]   def_q;
  logic [NUM_SLOT-1:0] hit_w, allow_w, svc_w;
  logic                found_w;
  logic [SLOT_W-1:0]   win_w;
  logic [DATA_W-1:0]   vect_w, rd_nxt;

  // ---------------- decode ----------------
  logic       aligned;
  logic [3:0] page;
  logic [5:0] widx;
  logic       slot_ok;
  logic [SLOT_W-1:0] sidx;
  assign aligned = (addr_i[1:0] == 2'b00);
  assign page    = addr_i[REG_AW-1:8];
  assign widx    = addr_i[7:2];
  assign slot_ok = aligned && (int'(widx) < NUM_SLOT);
  assign sidx    = widx[SLOT_W-1:0];

  logic wr_ctl, wr_hadr, push_w, pop_w;
  assign wr_ctl  = wr_en_i && slot_ok && (page == PAGE_CTL);
  assign wr_hadr = wr_en_i && slot_ok && (page == PAGE_HADR);
  assign pop_w   = wr_en_i && (addr_i == OFF_VECT);
  assign push_w  = rd_en_i && (addr_i == OFF_VECT) && found_w;

  // ---------------- request path ----------------
  assign raw_w = req_i | soft_q;
  assign act_w = raw_w & en_q;

  for (genvar k = 0; k < NUM_SLOT; k++) begin : g_slot
    logic [SRC_W-1:0] src;
    assign src      = ctl_q[k][SRC_W-1:0];
    assign hit_w[k] = ctl_q[k][SRC_W] && act_w[src] && !cls_q[src];
  end

  vic_slot_arbiter #(.NUM_SLOT(NUM_SLOT)) u_arb (
    .hit_i(hit_w), .allow_i(allow_w), .found_o(found_w), .idx_o(win_w)
  );

  vic_service_track #(.NUM_SLOT(NUM_SLOT)) u_svc (
    .clk(clk), .rst(rst), .push_i(push_w), .push_idx_i(win_w),
    .pop_i(pop_w), .allow_o(allow_w), .svc_o(svc_w)
  );

  assign vect_w = found_w ? hadr_mem[win_w] : def_q;

  // ---------------- read mux ----------------
  always_comb begin
    rd_nxt = '0;
    if (aligned) begin
      unique case (addr_i)
        OFF_RAW:    rd_nxt = DATA_W'(raw_w);
        OFF_IRQST:  rd_nxt = DATA_W'(act_w & ~cls_q);
        OFF_FIQST:  rd_nxt = DATA_W'(act_w & cls_q);
        OFF_ENSET:  rd_nxt = DATA_W'(en_q);
        OFF_CLASS:  rd_nxt = DATA_W'(cls_q);
        OFF_SSET:   rd_nxt = DATA_W'(soft_q);
        OFF_VECT:   rd_nxt = vect_w;
        OFF_DEFVEC: rd_nxt = def_q;
        default: begin
          if (slot_ok && page == PAGE_CTL)  rd_nxt = DATA_W'(ctl_q[sidx]);
          if (slot_ok && page == PAGE_HADR) rd_nxt = hadr_mem[sidx];
        end
      endcase
    end
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= '0;
      cls_q   <= '0;
      soft_q  <= '0;
      def_q   <= '0;
      fiq_o   <= 1'b0;
      irq_o   <= 1'b0;
      rdata_o <= '0;
      for (int k = 0; k < NUM_SLOT; k++) ctl_q[k] <= '0;
    end else begin
      fiq_o   <= |(act_w & cls_q);
      irq_o   <= |(act_w & ~cls_q);
      rdata_o <= rd_en_i ? rd_nxt : '0;
      if (wr_en_i) begin
        unique case (addr_i)
          OFF_ENSET:  en_q   <= en_q | wdata_i[NUM_SRC-1:0];
          OFF_ENCLR:  en_q   <= en_q & ~wdata_i[NUM_SRC-1:0];
          OFF_CLASS:  cls_q  <= wdata_i[NUM_SRC-1:0];
          OFF_SSET:   soft_q <= soft_q | wdata_i[NUM_SRC-1:0];
          OFF_SCLR:   soft_q <= soft_q & ~wdata_i[NUM_SRC-1:0];
          OFF_DEFVEC: def_q  <= wdata_i;
          default: ;
        endcase
      end
      if (wr_ctl) ctl_q[sidx] <= wdata_i[CTL_W-1:0];
    end
  end

  // handler table: plain write port, no reset, so it can map to RAM
  always_ff @(posedge clk) begin
    if (wr_hadr) hadr_mem[sidx] <= wdata_i;
  end
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk
  import vic_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_SLOT = 16,
  parameter int DATA_W   = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                rd_en_i,
  input logic                wr_en_i,
  input logic [REG_AW-1:0]   addr_i,
  input logic [DATA_W-1:0]   wdata_i,
  input logic [DATA_W-1:0]   rdata_o,
  input logic                fiq_o,
  input logic                irq_o,
  input logic [NUM_SRC-1:0]  raw_w,
  input logic [NUM_SRC-1:0]  soft_q,
  input logic                push_w,
  input logic                pop_w,
  input logic [NUM_SLOT-1:0] svc_w
);
  p_quiet_no_request_r4: assert property (@(posedge clk) disable iff (rst)
    !(|$past(raw_w)) |-> (!fiq_o && !irq_o));

  p_rdata_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_en_i) |-> (rdata_o == '0));

  p_soft_clear_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en_i) && $past(addr_i) == OFF_SCLR)
      |-> ((soft_q & $past(wdata_i[NUM_SRC-1:0])) == '0));

  p_pop_one_r10: assert property (@(posedge clk) disable iff (rst)
    ($past(pop_w) && !$past(push_w) && $past(svc_w) != '0)
      |-> ($countones(svc_w) == $countones($past(svc_w)) - 1));

  p_push_one_r10: assert property (@(posedge clk) disable iff (rst)
    ($past(push_w) && !$past(pop_w))
      |-> ($countones(svc_w) == $countones($past(svc_w)) + 1));
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(
  .NUM_SRC(NUM_SRC), .NUM_SLOT(NUM_SLOT), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .rd_en_i(rd_en_i), .wr_en_i(wr_en_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
  .fiq_o(fiq_o), .irq_o(irq_o), .raw_w(raw_w), .soft_q(soft_q),
  .push_w(push_w), .pop_w(pop_w), .svc_w(svc_w)
);

// File: tb/test_irq_vector_ctrl.sv
`timescale 1ns/1ps
module test_irq_vector_ctrl;
  import vic_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] req = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        fiq, irq;

  irq_vector_ctrl i_irq_vector_ctrl (
    .clk(clk), .rst(rst), .req_i(req), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .fiq_o(fiq), .irq_o(irq)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  // ---------------- model ----------------
  logic [31:0] m_en = '0, m_cls = '0, m_soft = '0, m_def = '0;
  logic [5:0]  m_ctl  [16];
  logic [31:0] m_hadr [16];
  logic [15:0] m_svc = '0;

  function automatic logic [31:0] m_act();
    return (req | m_soft) & m_en;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic m_vector(output logic [31:0] v);
    logic [15:0] allow;
    int win;
    win = -1;
    if (m_svc == 0) allow = '1;
    else allow = (m_svc & (~m_svc + 16'd1)) - 16'd1;
    for (int k = 15; k >= 0; k--) begin
      if (m_ctl[k][5] && m_act()[m_ctl[k][4:0]] && !m_cls[m_ctl[k][4:0]] && allow[k])
        win = k;
    end
    if (win >= 0) begin
      v = m_hadr[win];
      m_svc[win] = 1'b1;
    end else v = m_def;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
    if (a[1:0] == 2'b00) begin
      case (a)
        OFF_ENSET:  m_en   = m_en | d;
        OFF_ENCLR:  m_en   = m_en & ~d;
        OFF_CLASS:  m_cls  = d;
        OFF_SSET:   m_soft = m_soft | d;
        OFF_SCLR:   m_soft = m_soft & ~d;
        OFF_DEFVEC: m_def  = d;
        OFF_VECT:   m_svc  = m_svc & (m_svc - 16'd1);
        default: begin
          if (a[11:8] == 4'h1 && a[7:2] < 16) m_ctl[a[5:2]]  = d[5:0];
          if (a[11:8] == 4'h2 && a[7:2] < 16) m_hadr[a[5:2]] = d;
        end
      endcase
    end
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(posedge clk); #1;
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic rd_vec(input string tag);
    logic [31:0] d, e;
    m_vector(e);
    rd(OFF_VECT, d);
    chk(tag, d, e);
  endtask

  task automatic chk_lines(input string tag);
    @(posedge clk); #1;
    chk({tag, " fiq"}, {31'd0, fiq}, {31'd0, |(m_act() & m_cls)});
    chk({tag, " irq"}, {31'd0, irq}, {31'd0, |(m_act() & ~m_cls)});
  endtask

  initial begin
    logic [31:0] d;
    void'($urandom(32'd2024));
    for (int k = 0; k < 16; k++) begin m_ctl[k] = '0; m_hadr[k] = '0; end
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    #1;
    chk("R1 fiq reset", {31'd0, fiq}, 32'd0);
    chk("R1 irq reset", {31'd0, irq}, 32'd0);
    chk("R1 rdata reset", rdata, 32'd0);
    rd(OFF_ENSET, d);  chk("R1 enable reset", d, 32'd0);
    rd(OFF_DEFVEC, d); chk("R1 default reset", d, 32'd0);
    rd(12'h104, d);    chk("R1 slot ctl reset", d, 32'd0);

    // random phase over status, enable, class and soft-force
    for (int it = 0; it < 40; it++) begin
      @(negedge clk); req = $urandom;
      case ($urandom % 5)
        0: wr(OFF_ENSET, $urandom);
        1: wr(OFF_ENCLR, $urandom);
        2: wr(OFF_CLASS, $urandom);
        3: wr(OFF_SSET,  $urandom & $urandom);
        default: wr(OFF_SCLR, $urandom);
      endcase
      chk_lines("R4 R5 random");
      rd(OFF_RAW, d);   chk("R2 raw", d, req | m_soft);
      rd(OFF_IRQST, d); chk("R5 irq status", d, m_act() & ~m_cls);
      rd(OFF_FIQST, d); chk("R4 fiq status", d, m_act() & m_cls);
      rd(OFF_ENSET, d); chk("R3 enable", d, m_en);
      rd(OFF_SSET, d);  chk("R6 soft", d, m_soft);
    end

    // zero bits leave enables and soft bits untouched
    wr(OFF_ENSET, 32'h0000_00F0); wr(OFF_ENSET, 32'h0);
    rd(OFF_ENSET, d); chk("R3 zero write keeps", d, m_en);
    wr(OFF_SCLR, 32'h0);
    rd(OFF_SSET, d);  chk("R6 zero clear keeps", d, m_soft);

    // vectored setup
    @(negedge clk); req = '0;
    wr(OFF_SCLR, 32'hFFFF_FFFF);
    wr(OFF_ENSET, 32'hFFFF_FFFF);
    wr(OFF_CLASS, 32'h0);
    wr(OFF_DEFVEC, 32'h0000_DEF0);
    for (int k = 0; k < 16; k++) wr(12'h200 + 12'(4*k), 32'h1000_0000 + 32'(k));
    wr(12'h100, 32'h07);            // slot0 source 7 disabled
    wr(12'h104, 32'h29);            // slot1 source 9 enabled
    wr(12'h10C, 32'h27);            // slot3 source 7 enabled
    wr(12'h114, 32'h27);            // slot5 source 7 enabled (duplicate)
    rd(12'h10C, d); chk("R7 ctl readback", d, 32'h27);
    rd(12'h20C, d); chk("R7 addr readback", d, 32'h1000_0003);

    rd_vec("R8 idle default");
    @(negedge clk); req = 32'h80;
    chk_lines("R5 vectored irq");
    rd_vec("R9 duplicate lowest slot");
    rd_vec("R10 hold masks same level");
    @(negedge clk); req = 32'h280;
    rd_vec("R10 preempt by higher slot");
    @(negedge clk); req = 32'h80;
    wr(OFF_VECT, 32'h1234_5678);
    rd_vec("R10 release innermost only");
    wr(OFF_VECT, 32'hFFFF_FFFF);
    rd(OFF_DEFVEC, d); chk("R10 write data ignored", d, 32'h0000_DEF0);
    rd_vec("R10 release then reenter");
    wr(OFF_VECT, 32'h0);

    // non-vectored request
    @(negedge clk); req = 32'h0010_0000;
    chk_lines("R8 non-vectored irq");
    rd_vec("R8 non-vectored default");

    // slot disabled while its source requests
    wr(12'h10C, 32'h07); wr(12'h114, 32'h07);
    @(negedge clk); req = 32'h80;
    chk_lines("R7 disabled slot irq");
    rd_vec("R7 disabled slot default");
    wr(12'h114, 32'h27);
    rd_vec("R7 re-enabled slot5");
    wr(OFF_VECT, 32'h0);

    // fast class removes source from vectoring
    wr(OFF_CLASS, 32'h80);
    chk_lines("R4 fast class");
    rd_vec("R7 fast class not vectored");
    wr(OFF_CLASS, 32'h0);

    // soft-forced source is vectored
    @(negedge clk); req = '0;
    wr(OFF_SSET, 32'h200);
    rd(OFF_RAW, d); chk("R6 soft in raw", d, 32'h200);
    rd_vec("R6 soft vectored");
    wr(OFF_VECT, 32'h0);
    wr(OFF_SCLR, 32'h200);

    // misaligned and unmapped accesses
    wr(OFF_DEFVEC | 12'h1, 32'hBAD0_BAD0);
    rd(OFF_DEFVEC, d);         chk("R11 misaligned write ignored", d, m_def);
    rd(OFF_DEFVEC | 12'h2, d); chk("R11 misaligned read zero", d, 32'h0);
    rd(12'h300, d);            chk("R11 unmapped read zero", d, 32'h0);
    @(posedge clk); #1;
    chk("R11 rdata idle", rdata, 32'h0);

    // enable clear silences the outputs
    wr(OFF_ENCLR, 32'hFFFF_FFFF);
    @(negedge clk); req = 32'hFFFF_FFFF;
    chk_lines("R3 all disabled");

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule